// File: doc/BRIEF.md
# Serial Identity Code Shifter

This block keeps the 64-bit factory identity of a single-wire slave device and sends it one bit at a time after the read-identity command has been accepted. The code has three fields. The lowest byte holds the device family value. The next 48 bits hold the serial number. The top byte holds an 8-bit CRC taken over the 56 bits below it. The time-slot engine asks for one bit per read slot through a request strobe. The bit this block presents goes to an open-drain driver, so a 1 means the line is released. If several slaves answer at once, the line shows their wired-AND. For that reason the read-identity command is only meaningful when a single slave is on the line.

The CRC byte is never stored. While the 56 body bits go out, the block runs the CRC over them. It then shifts the remainder out as the last eight bits. The same CRC engine gives the master side a second mode: at start the block takes in 64 received bits instead of sending, and then reports whether the remainder over all of them is zero. A bus reset (abort) stops a transfer at any bit.

Top module: `idcode_shifter`

## Requirements
- R1: While `rst_n` is low, and right after reset, `done` is 0, `crcOk` is 0 and `txBit` is 1.
- R2: In send mode (`chkMode` = 0 when `start` is taken), `txBit` presents bit 0 right after start. The first eight bits are the family code (default 09h), least significant bit first.
- R3: Send bits 8 to 55 are the 48-bit serial number, least significant bit first.
- R4: Send bits 56 to 63 are the CRC of bits 0 to 55, least significant bit first. The CRC is x^8+x^5+x^4+1 in reflected form (mask 8Ch) with an initial value of 0. For each bit, the input bit is XORed with the register LSB, the register shifts right, and the mask is XORed in when that feedback is 1.
- R5: Each cycle with `bitReq` high during a transfer advances exactly one bit, and the new bit appears the next cycle. With no request, `txBit` holds.
- R6: The cycle after the 64th request, `done` goes to 1. After that `txBit` stays 1 and further requests have no effect until the next `start`.
- R7: `abort` at any point makes `done` 0, `crcOk` 0 and `txBit` 1 the next cycle. Requests have no effect after that until a new `start`.
- R8: In check mode (`chkMode` = 1 when `start` is taken), `txBit` stays 1 and `rxBit` is taken in on each request. After 64 bits, `done` goes to 1 and `crcOk` is 1 exactly when the CRC remainder over all 64 bits is zero.
- R9: A complete send ends with `crcOk` = 1.
- R10: A `start` during a transfer restarts at bit 0 with a cleared CRC.
- R11: When `abort` and `start` are high in the same cycle, `abort` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (read-identity command accepted) |
| bitReq | input | 1 | Per-slot request to advance one bit |
| abort | input | 1 | Bus reset pulse; ends the transfer |
| chkMode | input | 1 | Sampled at start: 1 selects check mode |
| rxBit | input | 1 | Received bit taken in by check mode |
| txBit | output | 1 | Bit to drive; 1 releases the line |
| done | output | 1 | Transfer of 64 bits finished |
| crcOk | output | 1 | Remainder over 64 bits was zero |

## Verification
The bench goes after the field boundaries at bits 7/8 and 55/56. A design that indexes the fields wrongly or sends them MSB first shows wrong bits there. It also drives extra requests after completion and after an abort: a design that keeps shifting would show code bits where 1s belong. It issues abort and start in the same cycle, and a restart in the middle of a transfer. It runs check mode on a good code, on a code with one bit flipped and on an all-zero stream. A CRC with the wrong mask, the wrong initial value or the wrong shift direction reports the wrong `crcOk` in at least one of those runs.

// File: rtl/idcode_pkg.sv
`timescale 1ns/1ps
package idcode_pkg;
  localparam int CRC_W = 8;

  typedef struct packed {
    logic clr;
    logic load;
    logic step;
    logic fin;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } shiftState_t;

  function automatic logic [CRC_W-1:0] crcStep(
    input logic [CRC_W-1:0] cur,
    input logic             inBit,
    input logic [CRC_W-1:0] mask
  );
    logic fb;
    logic [CRC_W-1:0] nxt;
    fb  = cur[0] ^ inBit;
    nxt = cur >> 1;
    if (fb) nxt = nxt ^ mask;
    return nxt;
  endfunction
endpackage

// File: rtl/idcode_ctrl.sv
`timescale 1ns/1ps
module idcode_ctrl
  import idcode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bitReq,
  input  logic        abort,
  input  logic        lastBit,
  output ctrlStrobe_t strobe,
  output logic        done
);
  shiftState_t state, stateNext;

  always_comb begin
    strobe.clr  = abort;
    strobe.load = start && !abort;
    strobe.step = bitReq && !start && !abort && (state == ST_SHIFT);
    strobe.fin  = strobe.step && lastBit;
  end

  always_comb begin
    stateNext = state;
    if (strobe.clr)       stateNext = ST_IDLE;
    else if (strobe.load) stateNext = ST_SHIFT;
    else if (strobe.fin)  stateNext = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign done = (state == ST_DONE);

  // R7: abort clears completion the next cycle
  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !done);

  // R6: completion only follows the final request
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(strobe.fin));

  // R11: abort wins over a simultaneous start
  assert_abort_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && start) |=> (state == ST_IDLE));
endmodule

// File: rtl/idcode_dpath.sv
`timescale 1ns/1ps
module idcode_dpath
  import idcode_pkg::*;
#(
  parameter logic [7:0] FAMILY_CODE = 8'h09,
  parameter int         SERIAL_W    = 48,
  parameter logic [SERIAL_W-1:0] SERIAL_NUM = 48'h00A5_3C96_0F71,
  parameter logic [CRC_W-1:0]    CRC_MASK   = 8'h8C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strobe,
  input  logic        chkMode,
  input  logic        rxBit,
  output logic        txBit,
  output logic        lastBit,
  output logic        crcOk
);
  localparam int FAM_W  = 8;
  localparam int BODY_W = FAM_W + SERIAL_W;
  localparam int CODE_W = BODY_W + CRC_W;
  localparam int IDX_W  = $clog2(CODE_W);

  localparam logic [BODY_W-1:0] BODY = {SERIAL_NUM, FAMILY_CODE};

  logic [IDX_W-1:0] bitIdx;
  logic [CRC_W-1:0] crcReg, crcNext;
  logic             busy, chkLatched;
  logic             inBody, curTx, consumed;

  assign inBody   = bitIdx < IDX_W'(BODY_W);
  assign curTx    = inBody ? BODY[bitIdx] : crcReg[0];
  assign consumed = chkLatched ? rxBit : curTx;
  assign crcNext  = crcStep(crcReg, consumed, CRC_MASK);
  assign txBit    = (busy && !chkLatched) ? curTx : 1'b1;
  assign lastBit  = (bitIdx == IDX_W'(CODE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitIdx     <= '0;
      crcReg     <= '0;
      busy       <= 1'b0;
      chkLatched <= 1'b0;
      crcOk      <= 1'b0;
    end else if (strobe.clr) begin
      bitIdx <= '0;
      crcReg <= '0;
      busy   <= 1'b0;
      crcOk  <= 1'b0;
    end else if (strobe.load) begin
      bitIdx     <= '0;
      crcReg     <= '0;
      busy       <= 1'b1;
      chkLatched <= chkMode;
      crcOk      <= 1'b0;
    end else if (strobe.step) begin
      crcReg <= crcNext;
      if (strobe.fin) begin
        bitIdx <= '0;
        busy   <= 1'b0;
        crcOk  <= (crcNext == '0);
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // R5: each accepted request advances by exactly one bit
  assert_step_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && !strobe.fin) |=> (bitIdx == $past(bitIdx) + 1'b1));

  // R5: without a request, load or abort the driven bit holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.step && !strobe.load && !strobe.clr) |=> $stable(txBit));

  // R9: shifting the remainder out leaves a zero remainder
  assert_crc_selfcheck_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fin && !chkLatched) |=> crcOk);

  // R2: the low byte presented equals the family code
  assert_family_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !chkLatched && bitIdx < IDX_W'(FAM_W)) |-> (txBit == FAMILY_CODE[bitIdx[2:0]]));
endmodule

// File: rtl/idcode_shifter.sv
`timescale 1ns/1ps
module idcode_shifter
  import idcode_pkg::*;
#(
  parameter logic [7:0] FAMILY_CODE = 8'h09,
  parameter int         SERIAL_W    = 48,
  parameter logic [SERIAL_W-1:0] SERIAL_NUM = 48'h00A5_3C96_0F71,
  parameter logic [7:0] CRC_MASK    = 8'h8C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bitReq,
  input  logic abort,
  input  logic chkMode,
  input  logic rxBit,
  output logic txBit,
  output logic done,
  output logic crcOk
);
  ctrlStrobe_t strobe;
  logic        lastBit;

  idcode_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .bitReq  (bitReq),
    .abort   (abort),
    .lastBit (lastBit),
    .strobe  (strobe),
    .done    (done)
  );

  idcode_dpath #(
    .FAMILY_CODE (FAMILY_CODE),
    .SERIAL_W    (SERIAL_W),
    .SERIAL_NUM  (SERIAL_NUM),
    .CRC_MASK    (CRC_MASK)
  ) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .chkMode (chkMode),
    .rxBit   (rxBit),
    .txBit   (txBit),
    .lastBit (lastBit),
    .crcOk   (crcOk)
  );
endmodule

// File: tb/idcode_shifter_bench.sv
`timescale 1ns/1ps
module idcode_shifter_bench;
  localparam logic [7:0]  FAM = 8'h09;
  localparam logic [47:0] SER = 48'h00A5_3C96_0F71;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bitReq = 1'b0, abort = 1'b0, chkMode = 1'b0, rxBit = 1'b0;
  logic txBit, done, crcOk;

  always #2.5 clk = ~clk;

  idcode_shifter #(.FAMILY_CODE(FAM), .SERIAL_W(48), .SERIAL_NUM(SER), .CRC_MASK(8'h8C)) u_idcode_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .bitReq(bitReq), .abort(abort),
    .chkMode(chkMode), .rxBit(rxBit), .txBit(txBit), .done(done), .crcOk(crcOk)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string phaseTag = "R1";

  bit codeBits[64];
  int mIdx = 0;
  bit mActive = 0, mDone = 0, mOk = 0, mChk = 0;
  bit rxq[$];

  function automatic int refCrc(input bit q[$]);
    int r = 0;
    foreach (q[k]) begin
      int fb = (r & 1) ^ int'(q[k]);
      r = r >> 1;
      if (fb != 0) r = r ^ 'h8C;
    end
    return r;
  endfunction

  initial begin
    bit body[$];
    int c;
    for (int i = 0; i < 8; i++)  begin codeBits[i] = FAM[i];   body.push_back(FAM[i]); end
    for (int i = 8; i < 56; i++) begin codeBits[i] = SER[i-8]; body.push_back(SER[i-8]); end
    c = refCrc(body);
    for (int i = 0; i < 8; i++) codeBits[56+i] = bit'((c >> i) & 1);
  end

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      mActive = 0; mDone = 0; mOk = 0; mIdx = 0; mChk = 0;
    end else if (abort) begin
      mActive = 0; mDone = 0; mOk = 0;
    end else if (start) begin
      mActive = 1; mDone = 0; mOk = 0; mIdx = 0; mChk = chkMode;
      rxq.delete();
    end else if (bitReq && mActive) begin
      if (mChk) rxq.push_back(rxBit);
      mIdx++;
      if (mIdx == 64) begin
        mActive = 0; mDone = 1;
        mOk = mChk ? (refCrc(rxq) == 0) : 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    bit expTx;
    string txTag;
    expTx = (mActive && !mChk) ? codeBits[mIdx] : 1'b1;
    if (mActive && !mChk) txTag = (mIdx < 8) ? "R2" : (mIdx < 56) ? "R3" : "R4";
    else txTag = phaseTag;
    compared++;
    if (txBit !== expTx) begin
      mismatched++;
      $display("FAIL %s txBit got %b exp %b (bit %0d)", txTag, txBit, expTx, mIdx);
    end
    compared++;
    if (done !== mDone) begin
      mismatched++;
      $display("FAIL %s done got %b exp %b", phaseTag, done, mDone);
    end
    compared++;
    if (crcOk !== mOk) begin
      mismatched++;
      $display("FAIL %s crcOk got %b exp %b", phaseTag, crcOk, mOk);
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic cyc(input bit s, input bit b, input bit a, input bit c, input bit rx);
    start = s; bitReq = b; abort = a; chkMode = c; rxBit = rx;
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset values
    phaseTag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // R2 R3 R4 R5: send with gaps between requests
    phaseTag = "R5";
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 64; i++) begin
      cyc(0, 1, 0, 0, 0);
      if (i % 3 == 0) idle(2);
    end
    // R6 R9: done then extra requests ignored
    phaseTag = "R6";
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0);
    idle(2);

    // back-to-back send
    phaseTag = "R9";
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, 0);
    idle(2);

    // R7: abort mid-transfer, later requests ignored
    phaseTag = "R7";
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 0);
    // abort right after done
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    idle(2);

    // R11: abort beats start
    phaseTag = "R11";
    cyc(1, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0);

    // R10: restart during transfer
    phaseTag = "R10";
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 30; i++) cyc(0, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, 0);
    idle(2);

    // R8: check mode, good code
    phaseTag = "R8";
    cyc(1, 0, 0, 1, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, codeBits[i]);
    idle(2);
    // R8: check mode, one bit flipped
    cyc(1, 0, 0, 1, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, codeBits[i] ^ (i == 17));
    idle(2);
    // R8: check mode, flipped CRC bit
    cyc(1, 0, 0, 1, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, codeBits[i] ^ (i == 60));
    idle(2);
    // R8: check mode, all zeros
    cyc(1, 0, 0, 1, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, 0);
    idle(3);

    finishRun();
  end
endmodule